// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block divides its clock by a programmable count N and drives a high pulse, one clock wide, once every N clocks. The count is held in three sections that borrow from one another: a fast first section whose modulus (2, 4, 5, 8 or 10) is chosen by a three-bit mode code, a chain of three BCD decades, and a thousands section built from the low preset bits the first section does not need. A 16-bit preset word supplies the starting value. Each time the count reaches its end the block reloads the preset word, so the output runs periodically without any outside help.

One mode code family parks the block in a preset state. In that state every section is reloaded from the preset word on every clock. When the mode leaves the preset state, one clock goes to arming, so the first pulse arrives N+1 clocks later. A latch-enable input can hold the output high after a pulse. A protocol-error output flags any entry into divide-by-5 that does not come straight from a preset state held long enough. All pins are plain control and status lines. Nothing flows as a stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `ndiv_counter`

## Requirements
- R1: The mode code mode_i = {a,b,c} selects the first-section modulus M: 111 gives 2, 011 gives 4, 101 gives 5, 001 gives 8, and 110 or 010 give 10. In every mode the pulse period is N = M*(1000*L + 100*D2 + 10*D1 + D0) + F. The fields are D0 = jam_i[7:4], D1 = jam_i[11:8] and D2 = jam_i[15:12]. F is the low log2-width field of jam_i[3:0], one bit for M=2, two bits for M=4, three bits for M=5 or 8, and four bits for M=10. L is the rest of jam_i[3:0] above F.
- R2: Each decade field may hold 10 to 15, and it then contributes its full binary value to N.
- R3: With latch_en_i low, each pulse on div_o lasts exactly one clock.
- R4: In a steady run, consecutive rising edges of div_o are exactly N clocks apart, because the preset word is reloaded at each pulse.
- R5: Any code with b=0 and c=0 is the preset state. Once it has been held for two clocks, div_o stays low (with latch_en_i low). After the mode leaves it, the first pulse appears N+1 clocks later.
- R6: If the preset state is entered with one or two clocks left before a pulse is due, that pulse still appears at its due clock. If three or more clocks are left, no pulse is issued.
- R7: With latch_en_i high, div_o stays high from a pulse until latch_en_i is low at a clock edge.
- R8: proto_err_o pulses for one clock after a clock edge that enters divide-by-5 (code 101), unless the three edges just before it all sampled the preset state.
- R9: A synchronous active-high rst loads the preset word, clears the arming and latch state, and drives div_o and proto_err_o low. If the mode is a divide mode when rst is released, the first pulse follows N+1 clocks later.
- R10: The thousands section holds at most 7, 3, 1 and 1 for M = 2, 4, 5 and 8. It is absent for M=10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| jam_i | input | 16 | Preset word: first/last fields in [3:0], decades in [7:4], [11:8], [15:12] |
| mode_i | input | 3 | Mode code {a,b,c} |
| latch_en_i | input | 1 | Holds div_o high after a pulse while set |
| div_o | output | 1 | Divided pulse output |
| proto_err_o | output | 1 | One-clock flag for an illegal entry into divide-by-5 |

## Verification
The main sweep covers every divide mode, every legal first-section preset, and decade values of 1 and 2. This shows whether the first section wraps and borrows into the decade chain correctly at every boundary. Further patterns set a decade to 15, set the thousands section to its mode maximum, and mix digits across all three decades. These separate a decade that wraps at 9 from one that wraps at 15, and show whether the thousands section is split off correctly for each mode. Preset entries timed three, two and one clock before a due pulse show whether late pulses are kept or dropped. Entries into divide-by-5 after two preset clocks, after three preset clocks and directly from divide-by-10 show the exact hold limit.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

  typedef enum logic [2:0] {
    MD_DIV2,
    MD_DIV4,
    MD_DIV5,
    MD_DIV8,
    MD_DIV10,
    MD_PRESET
  } ndiv_mode_e;

  typedef struct packed {
    logic [3:0] modulus;     // first-section modulus
    logic [2:0] first_bits;  // preset bits taken by the first section
    logic [3:0] last_mod;    // thousands-section modulus (1 = absent)
  } ndiv_layout_t;

  function automatic ndiv_mode_e decode_mode(input logic [2:0] k);
    ndiv_mode_e m;
    if (k[1:0] == 2'b00) m = MD_PRESET;
    else begin
      case (k)
        3'b111:  m = MD_DIV2;
        3'b011:  m = MD_DIV4;
        3'b101:  m = MD_DIV5;
        3'b001:  m = MD_DIV8;
        default: m = MD_DIV10;
      endcase
    end
    return m;
  endfunction

  function automatic ndiv_layout_t layout_of(input ndiv_mode_e m);
    ndiv_layout_t l;
    case (m)
      MD_DIV2: l = '{modulus: 4'd2, first_bits: 3'd1, last_mod: 4'd8};
      MD_DIV4: l = '{modulus: 4'd4, first_bits: 3'd2, last_mod: 4'd4};
      MD_DIV5: l = '{modulus: 4'd5, first_bits: 3'd3, last_mod: 4'd2};
      MD_DIV8: l = '{modulus: 4'd8, first_bits: 3'd3, last_mod: 4'd2};
      default: l = '{modulus: 4'd10, first_bits: 3'd4, last_mod: 4'd1};
    endcase
    return l;
  endfunction

endpackage

// File: rtl/ndiv_digit.sv
module ndiv_digit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic [W-1:0] wrap,
  output logic [W-1:0] cur,
  output logic         at_zero
);

  // A single down-counting stage that wraps to a runtime value on borrow.
  always_ff @(posedge clk) begin
    if (load)      cur <= ld_val;
    else if (step) cur <= (cur == '0) ? wrap : cur - 1'b1;
  end

  assign at_zero = (cur == '0);

endmodule

// File: rtl/ndiv_guard.sv
module ndiv_guard #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic is_pre,
  input  logic is_div5,
  output logic proto_err
);

  localparam int RW = $clog2(HOLD + 1);

  logic [RW-1:0] pre_run;
  logic          prev_div5;

  // pre_run counts consecutive preset edges, saturating at HOLD.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_run   <= '0;
      prev_div5 <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (!is_pre)                      pre_run <= '0;
      else if (pre_run != RW'(HOLD))    pre_run <= pre_run + 1'b1;
      prev_div5 <= is_div5;
      proto_err <= is_div5 && !prev_div5 && (pre_run != RW'(HOLD));
    end
  end

endmodule

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic is_pre,
  input  logic term,
  input  logic two_left,
  input  logic latch_en,
  output logic load,
  output logic step,
  output logic div_q
);

  logic arm;
  logic pend;
  logic fire;
  logic pulse_evt;

  assign fire      = arm && term;
  assign pulse_evt = fire || pend;
  assign load      = rst || is_pre || !arm || fire;
  assign step      = arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm   <= 1'b0;
      pend  <= 1'b0;
      div_q <= 1'b0;
    end else begin
      arm   <= !is_pre;
      // a pulse due on the next edge survives entry into preset
      pend  <= is_pre && arm && two_left && !term;
      div_q <= pulse_evt || (div_q && latch_en);
    end
  end

endmodule

// File: rtl/ndiv_counter.sv
module ndiv_counter
  import ndiv_pkg::*;
#(
  parameter int DIG_W   = 4,
  parameter int NUM_DEC = 3,
  parameter int LAST_W  = 3,
  parameter int HOLD    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DIG_W*(NUM_DEC+1)-1:0]  jam_i,
  input  logic [2:0]                    mode_i,
  input  logic                          latch_en_i,
  output logic                          div_o,
  output logic                          proto_err_o
);

  localparam int JAM_W = DIG_W * (NUM_DEC + 1);

  ndiv_mode_e   mode_now;
  ndiv_layout_t lay;
  logic         is_pre;
  logic [3:0]   run_mod;

  assign mode_now = decode_mode(mode_i);
  assign lay      = layout_of(mode_now);
  assign is_pre   = (mode_now == MD_PRESET);

  always_ff @(posedge clk) begin
    if (rst)          run_mod <= 4'd10;
    else if (!is_pre) run_mod <= lay.modulus;
  end

  logic                            load;
  logic                            step;
  logic [DIG_W-1:0]                fmask;
  logic [DIG_W-1:0]                f_ld;
  logic [LAST_W-1:0]               l_ld;
  logic [DIG_W-1:0]                f_val;
  logic                            f_zero;
  logic [LAST_W-1:0]               l_val;
  logic                            l_zero;
  logic [NUM_DEC-1:0][DIG_W-1:0]   dec_val;
  logic [NUM_DEC-1:0]              dec_zero;
  logic [NUM_DEC:0]                borrow;
  logic                            upper_zero;
  logic                            term;
  logic                            two_left;

  assign fmask = DIG_W'((32'd1 << lay.first_bits) - 32'd1);
  assign f_ld  = jam_i[DIG_W-1:0] & fmask;
  assign l_ld  = LAST_W'(jam_i[DIG_W-1:0] >> lay.first_bits);

  ndiv_digit #(.W(DIG_W)) u_first (
    .clk(clk), .load(load), .ld_val(f_ld), .step(step),
    .wrap(DIG_W'(lay.modulus - 4'd1)), .cur(f_val), .at_zero(f_zero)
  );

  assign borrow[0] = step && f_zero;

  genvar gi;
  for (gi = 0; gi < NUM_DEC; gi++) begin : g_dec
    ndiv_digit #(.W(DIG_W)) u_dig (
      .clk(clk), .load(load), .ld_val(jam_i[DIG_W*(gi+1) +: DIG_W]),
      .step(borrow[gi]), .wrap(DIG_W'(9)),
      .cur(dec_val[gi]), .at_zero(dec_zero[gi])
    );
    assign borrow[gi+1] = borrow[gi] && dec_zero[gi];
  end

  ndiv_digit #(.W(LAST_W)) u_last (
    .clk(clk), .load(load), .ld_val(l_ld), .step(borrow[NUM_DEC]),
    .wrap(LAST_W'(lay.last_mod - 4'd1)), .cur(l_val), .at_zero(l_zero)
  );

  assign upper_zero = (&dec_zero) && l_zero;
  assign term       = upper_zero && (f_val <= DIG_W'(1));
  assign two_left   = (upper_zero && f_val == DIG_W'(2)) ||
                      (run_mod == 4'd2 && f_zero && l_zero &&
                       dec_val[0] == DIG_W'(1) && (&dec_zero[NUM_DEC-1:1]));

  ndiv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .is_pre(is_pre), .term(term),
    .two_left(two_left), .latch_en(latch_en_i),
    .load(load), .step(step), .div_q(div_o)
  );

  ndiv_guard #(.HOLD(HOLD)) u_guard (
    .clk(clk), .rst(rst), .is_pre(is_pre),
    .is_div5(mode_now == MD_DIV5), .proto_err(proto_err_o)
  );

  logic unused_ok;
  assign unused_ok = ^{JAM_W};

endmodule

// File: rtl/ndiv_counter_chk.sv
module ndiv_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_i,
  input logic       latch_en_i,
  input logic       div_o,
  input logic       proto_err_o
);

  logic pre;
  assign pre = (mode_i[1:0] == 2'b00);

  AST_PRESET_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(pre) && $past(pre, 2) && !latch_en_i) |=> !div_o); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (div_o && latch_en_i) |=> div_o); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |-> ($past(mode_i) == 3'b101)); // R8

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> !proto_err_o); // R8

  AST_ERR_HELD_OK: assert property (@(posedge clk) disable iff (rst)
    ($past(pre) && $past(pre, 2) && $past(pre, 3) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3) &&
     mode_i == 3'b101) |=> !proto_err_o); // R8

endmodule

bind ndiv_counter ndiv_counter_chk chk_i (
  .clk(clk), .rst(rst), .mode_i(mode_i), .latch_en_i(latch_en_i),
  .div_o(div_o), .proto_err_o(proto_err_o)
);

// File: tb/ndiv_counter_tb_top.sv
module ndiv_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] jam_i = '0;
  logic [2:0]  mode_i = 3'b110;
  logic        latch_en_i = 1'b0;
  logic        div_o;
  logic        proto_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ndiv_counter dut_i (
    .clk(clk), .rst(rst), .jam_i(jam_i), .mode_i(mode_i),
    .latch_en_i(latch_en_i), .div_o(div_o), .proto_err_o(proto_err_o)
  );

  function automatic logic [2:0] code_of(int mi);
    case (mi)
      0: return 3'b111;
      1: return 3'b011;
      2: return 3'b101;
      3: return 3'b001;
      default: return 3'b110;
    endcase
  endfunction
  function automatic int mod_of(int mi);
    case (mi) 0: return 2; 1: return 4; 2: return 5; 3: return 8; default: return 10; endcase
  endfunction
  function automatic int fb_of(int mi);
    case (mi) 0: return 1; 1: return 2; 2: return 3; 3: return 3; default: return 4; endcase
  endfunction
  function automatic int lmax_of(int mi);
    case (mi) 0: return 7; 1: return 3; 2: return 1; 3: return 1; default: return 0; endcase
  endfunction

  function automatic logic [15:0] make_jam(int mi, int f, int l, int d0, int d1, int d2);
    int low;
    low = f | (l << fb_of(mi));
    return {4'(d2), 4'(d1), 4'(d0), 4'(low)};
  endfunction

  function automatic int calc_n(int mi, int f, int l, int d0, int d1, int d2);
    return mod_of(mi) * (1000*l + 100*d2 + 10*d1 + d0) + f;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // leave preset and return the tick count of the first pulse
  task automatic first_pulse(logic [2:0] code, int lim, output int k1);
    k1 = -1;
    mode_i = code;
    for (int k = 1; k <= lim; k++) begin
      tick();
      if (div_o) begin k1 = k; break; end
    end
  endtask

  task automatic run_pattern(int mi, int f, int l, int d0, int d1, int d2, string tag);
    int n, k1, sp;
    n = calc_n(mi, f, l, d0, d1, d2);
    mode_i = 3'b000;
    jam_i = make_jam(mi, f, l, d0, d1, d2);
    repeat (3) tick();
    first_pulse(code_of(mi), n + 4, k1);
    check(k1 == n + 1, "R5", k1, n + 1);
    tick();
    check(!div_o, "R3", int'(div_o), 0);
    sp = -1;
    for (int j = 2; j <= n + 4; j++) begin
      tick();
      if (div_o) begin sp = j; break; end
    end
    check(sp == n, tag, sp, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k1;
    // R9: reset state
    jam_i = make_jam(4, 5, 0, 0, 0, 0);
    repeat (3) tick();
    check(div_o == 1'b0, "R9", int'(div_o), 0);
    check(proto_err_o == 1'b0, "R9", int'(proto_err_o), 0);
    rst = 1'b0;
    k1 = -1;
    for (int k = 1; k <= 12; k++) begin
      tick();
      if (div_o) begin k1 = k; break; end
    end
    check(k1 == 6, "R9", k1, 6);

    // R1: sweep of every mode, first-section value and small decade
    for (int mi = 0; mi < 5; mi++)
      for (int f = 0; f < mod_of(mi); f++)
        for (int d0 = 1; d0 <= 2; d0++)
          run_pattern(mi, f, 0, d0, 0, 0, "R1");

    for (int mi = 0; mi < 5; mi++) begin
      run_pattern(mi, mod_of(mi) - 1, 0, 15, 0, 0, "R2");
      run_pattern(mi, 0, lmax_of(mi), 0, 1, 0, "R10");
      run_pattern(mi, mod_of(mi) / 2, 0, 3, 2, 1, "R4");
    end

    // R6: preset entered 2, 1 and 3 clocks before a due pulse (N=20)
    mode_i = 3'b000;
    jam_i = make_jam(4, 0, 0, 2, 0, 0);
    repeat (3) tick();
    first_pulse(3'b110, 30, k1);
    repeat (18) tick();
    mode_i = 3'b000;
    tick();
    check(!div_o, "R6", int'(div_o), 0);
    tick();
    check(div_o, "R6", int'(div_o), 1);
    tick();
    first_pulse(3'b110, 30, k1);
    check(k1 == 21, "R5", k1, 21);
    repeat (19) tick();
    mode_i = 3'b000;
    tick();
    check(div_o, "R6", int'(div_o), 1);
    tick();
    tick();
    first_pulse(3'b110, 30, k1);
    repeat (17) tick();
    mode_i = 3'b000;
    k1 = 0;
    for (int j = 0; j < 5; j++) begin
      tick();
      if (div_o) k1++;
    end
    check(k1 == 0, "R6", k1, 0);

    // R7: latch hold then release
    latch_en_i = 1'b1;
    first_pulse(3'b110, 30, k1);
    k1 = 0;
    for (int j = 0; j < 5; j++) begin
      tick();
      if (div_o) k1++;
    end
    check(k1 == 5, "R7", k1, 5);
    latch_en_i = 1'b0;
    tick();
    check(!div_o, "R7", int'(div_o), 0);

    // R8: divide-by-5 entry rules
    mode_i = 3'b000;
    repeat (2) tick();
    mode_i = 3'b101;
    tick();
    check(proto_err_o, "R8", int'(proto_err_o), 1);
    tick();
    check(!proto_err_o, "R8", int'(proto_err_o), 0);
    mode_i = 3'b110;
    repeat (3) tick();
    mode_i = 3'b101;
    tick();
    check(proto_err_o, "R8", int'(proto_err_o), 1);
    mode_i = 3'b000;
    repeat (3) tick();
    mode_i = 3'b101;
    tick();
    check(!proto_err_o, "R8", int'(proto_err_o), 0);
    tick();
    check(!proto_err_o, "R8", int'(proto_err_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule